// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block drives the control strobes of one external memory channel: chip enable, output enable, write enable and a set of per-byte lane strobes. A client starts an access with a single-cycle request that carries a word address, write data, a byte mask, a read/write flag, a burst length and a burst direction. The sequencer then walks through a chain of timed phases: address setup, chip-enable setup, a strobe window with one wait run per beat, strobe hold and address hold. Read data comes back one beat at a time with a valid pulse, and a done pulse marks the end of the access.

Every phase length is a 4-bit setting from 0 to 15, and a zero setting removes that phase. The sequencer counts ticks of a slower strobe clock, which runs at the internal clock divided by 1, 2, 3 or 4. The first beat of an access uses the normal wait setting. Each later beat of a burst uses the page wait setting instead, with the strobe held low and the address stepped up or down by one word. A mode input selects how the lane strobes behave. In one mode they act as byte enables for the whole access. In the other they act as per-byte write pulses.

Top module: `xmem_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_bw_n` is all ones, and `busy`, `done` and `rd_valid` are 0.
- R2: One tick lasts `cfg_div`+1 internal clock cycles, where `cfg_div` is 0 to 3. Each phase of setting N lasts N ticks.
- R3: A request is accepted when `req_valid` is 1 while `busy` is 0. `mem_addr` takes `req_addr` at the accepting edge, and `mem_ce_n` falls `cfg_asu` ticks later. A zero setting makes it fall at the accepting edge itself.
- R4: The strobe (`mem_oe_n` for a read, `mem_we_n` for a write) falls `cfg_csu` ticks after `mem_ce_n` falls. The strobe is only ever low while `mem_ce_n` is low.
- R5: The strobe stays low for `cfg_nwait`+1 ticks for the first beat, plus `cfg_pwait`+1 ticks for each further beat. `mem_oe_n` and `mem_we_n` are never low together, and a read never lowers `mem_we_n`.
- R6: `mem_ce_n` rises `cfg_shld` ticks after the strobe rises.
- R7: `busy` falls `cfg_ahld` ticks after `mem_ce_n` rises. `mem_addr` changes during an access only at a beat boundary inside the strobe window.
- R8: A burst has `req_len`+1 beats. Beat k uses address `req_addr`+k, or `req_addr`−k when `req_down` is 1, taken modulo 2^ADDR_W.
- R9: For a read, `mem_din` is captured on the last cycle of each beat's strobe window. `rd_valid` is then high for one cycle per beat with that beat's word on `rd_data`, in beat order. A write raises no `rd_valid`.
- R10: When `cfg_be_mode` is 1, `mem_bw_n` equals the inverted mask whenever `mem_ce_n` is low, for reads and writes alike. When it is 0, `mem_bw_n` equals the inverted mask only while `mem_we_n` is low, and is all ones otherwise.
- R11: During a write, while `mem_ce_n` is low, `mem_dout_en` is 1 and `mem_dout` equals `req_wdata`. During a read, `mem_dout_en` stays 0.
- R12: `busy` is high from the accepting edge until the access ends. `done` is a single-cycle pulse in the first idle cycle, and a new request can be accepted in that same cycle.
- R13: All settings and request fields are sampled at the accepting edge. Changes to them, and any `req_valid`, while `busy` is 1 have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | 2 | Strobe clock divisor minus one |
| cfg_asu | input | 4 | Address-to-chip-enable setup ticks |
| cfg_csu | input | 4 | Chip-enable-to-strobe setup ticks |
| cfg_nwait | input | 4 | Extra strobe ticks on the first beat |
| cfg_pwait | input | 4 | Extra strobe ticks on each later beat |
| cfg_shld | input | 4 | Strobe-to-chip-enable hold ticks |
| cfg_ahld | input | 4 | Chip-enable-to-address hold ticks |
| cfg_be_mode | input | 1 | 1: lane strobes act as byte enables; 0: lane strobes act as write pulses |
| req_valid | input | 1 | Start an access (taken when idle) |
| req_write | input | 1 | 1 write, 0 read |
| req_down | input | 1 | Burst address counts down |
| req_len | input | 3 | Beats minus one |
| req_addr | input | 16 | Start word address |
| req_mask | input | 4 | Byte lanes, active high |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished (one cycle) |
| rd_valid | output | 1 | Read beat captured |
| rd_data | output | 32 | Captured read word |
| mem_addr | output | 16 | External address |
| mem_dout | output | 32 | External write data |
| mem_dout_en | output | 1 | Drive enable for write data |
| mem_din | input | 32 | External read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bw_n | output | 4 | Byte lane strobes, active low |

## Verification
The assertions assume that reset is held for at least one clock before the first request. They also assume that the divisor and phase settings take effect only through an accepted request, so the strobe clock restarts whenever the settings it uses change. The stimulus drives every input on the falling clock edge. It raises `req_valid` for exactly one cycle while the block is idle. Any extra `req_valid`, altered settings or altered address are applied only in cycles where the expected access is still at least two cycles from its end.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int PHW = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASU,
    PH_CSU,
    PH_WAIT,
    PH_SHLD,
    PH_AHLD
  } phase_e;

  typedef struct packed {
    logic [PHW-1:0] asu;
    logic [PHW-1:0] csu;
    logic [PHW-1:0] nwait;
    logic [PHW-1:0] pwait;
    logic [PHW-1:0] shld;
    logic [PHW-1:0] ahld;
  } timing_t;
endpackage

// File: rtl/xmem_tick.sv
module xmem_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div_sel);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: with a divisor above one, two ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && div_sel != '0) |=> !tick);
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int BW    = 4,
  parameter int LW    = 3,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_down,
  input  logic [LW-1:0]    req_len,
  input  logic [AW-1:0]    req_addr,
  input  logic [BW-1:0]    req_mask,
  input  logic [DW-1:0]    req_wdata,
  input  timing_t          cfg_tm,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_be_mode,
  input  logic             tick,
  output phase_e           ph_q,
  output phase_e           ph_d,
  output logic             restart,
  output logic             beat_end,
  output logic [AW-1:0]    addr_q,
  output logic             wr_q,
  output logic             wr_d,
  output logic             bemode_d,
  output logic [BW-1:0]    mask_d,
  output logic [DW-1:0]    wdata_q,
  output logic [DIV_W-1:0] div_q
);
  timing_t        tm_q;
  logic [PHW-1:0] cnt_q, cnt_d;
  logic [LW-1:0]  beat_q, beat_d;
  logic [AW-1:0]  addr_d;
  logic           down_q;
  logic           bemode_q;
  logic [BW-1:0]  mask_q;
  logic           accept;

  function automatic phase_e after_asu(timing_t t);
    return (t.csu != '0) ? PH_CSU : PH_WAIT;
  endfunction

  function automatic phase_e after_idle(timing_t t);
    return (t.asu != '0) ? PH_ASU : after_asu(t);
  endfunction

  function automatic phase_e after_shld(timing_t t);
    return (t.ahld != '0) ? PH_AHLD : PH_IDLE;
  endfunction

  function automatic phase_e after_wait(timing_t t);
    return (t.shld != '0) ? PH_SHLD : after_shld(t);
  endfunction

  function automatic logic [PHW-1:0] load_for(phase_e p, timing_t t);
    case (p)
      PH_ASU:  return t.asu - PHW'(1);
      PH_CSU:  return t.csu - PHW'(1);
      PH_WAIT: return t.nwait;
      PH_SHLD: return t.shld - PHW'(1);
      PH_AHLD: return t.ahld - PHW'(1);
      default: return '0;
    endcase
  endfunction

  assign accept   = (ph_q == PH_IDLE) && req_valid;
  assign restart  = accept;
  assign wr_d     = accept ? req_write   : wr_q;
  assign bemode_d = accept ? cfg_be_mode : bemode_q;
  assign mask_d   = accept ? req_mask    : mask_q;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    beat_d   = beat_q;
    addr_d   = addr_q;
    beat_end = 1'b0;
    if (accept) begin
      ph_d   = after_idle(cfg_tm);
      cnt_d  = load_for(after_idle(cfg_tm), cfg_tm);
      beat_d = req_len;
      addr_d = req_addr;
    end else if (ph_q != PH_IDLE && tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        case (ph_q)
          PH_ASU:  ph_d = after_asu(tm_q);
          PH_CSU:  ph_d = PH_WAIT;
          PH_WAIT: begin
            beat_end = 1'b1;
            if (beat_q != '0) begin
              beat_d = beat_q - 1'b1;
              addr_d = down_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
            end else begin
              ph_d = after_wait(tm_q);
            end
          end
          PH_SHLD: ph_d = after_shld(tm_q);
          default: ph_d = PH_IDLE;
        endcase
        if (ph_q == PH_WAIT && ph_d == PH_WAIT) begin
          cnt_d = tm_q.pwait;
        end else begin
          cnt_d = load_for(ph_d, tm_q);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      beat_q   <= '0;
      addr_q   <= '0;
      tm_q     <= '0;
      wr_q     <= 1'b0;
      down_q   <= 1'b0;
      bemode_q <= 1'b0;
      mask_q   <= '0;
      wdata_q  <= '0;
      div_q    <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      addr_q <= addr_d;
      wr_q     <= wr_d;
      bemode_q <= bemode_d;
      mask_q   <= mask_d;
      if (accept) begin
        tm_q    <= cfg_tm;
        down_q  <= req_down;
        wdata_q <= req_wdata;
        div_q   <= cfg_div;
      end
    end
  end

  // R7: outside the strobe window the address is frozen for the whole access
  p_addr_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && ph_q != PH_WAIT) |=> $stable(addr_q));

  // R8: a beat boundary that keeps the strobe low moves the address by one word
  p_beat_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && beat_end && ph_d == PH_WAIT) |=>
      (addr_q == (down_q ? $past(addr_q) - 1'b1 : $past(addr_q) + 1'b1)));

  // R13: request fields are held while busy, whatever the request inputs do
  p_fields_held_r13: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |=> ($stable(wdata_q) && $stable(div_q)));
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        ph_q,
  input  phase_e        ph_d,
  input  logic          wr_q,
  input  logic          wr_d,
  input  logic          bemode_d,
  input  logic [BW-1:0] mask_d,
  input  logic          beat_end,
  input  logic [DW-1:0] mem_din,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [BW-1:0] bw_n,
  output logic          dout_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  logic ce_on, stb_on;

  assign ce_on  = (ph_d == PH_CSU) || (ph_d == PH_WAIT) || (ph_d == PH_SHLD);
  assign stb_on = (ph_d == PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      bw_n     <= '1;
      dout_en  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      ce_n    <= !ce_on;
      oe_n    <= !(stb_on && !wr_d);
      we_n    <= !(stb_on && wr_d);
      dout_en <= ce_on && wr_d;
      if (bemode_d) begin
        bw_n <= ce_on ? ~mask_d : '1;
      end else begin
        bw_n <= (stb_on && wr_d) ? ~mask_d : '1;
      end
      rd_valid <= beat_end && !wr_q;
      if (beat_end && !wr_q) begin
        rd_data <= mem_din;
      end
      done <= (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
    end
  end

  // R5: read and write strobes are mutually exclusive
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  // R4: a strobe is only low inside the chip-enable window
  p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |-> !ce_n);

  // R10: lane strobes are released whenever the chip is deselected
  p_lanes_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (bw_n == '1));

  // R12: the end-of-access flag lasts exactly one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 3,
  parameter int MAX_DIV = 4,
  localparam int BYTES  = DATA_W / 8,
  localparam int DIV_W  = $clog2(MAX_DIV),
  localparam int PH_W   = xmem_pkg::PHW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [PH_W-1:0]   cfg_asu,
  input  logic [PH_W-1:0]   cfg_csu,
  input  logic [PH_W-1:0]   cfg_nwait,
  input  logic [PH_W-1:0]   cfg_pwait,
  input  logic [PH_W-1:0]   cfg_shld,
  input  logic [PH_W-1:0]   cfg_ahld,
  input  logic              cfg_be_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_down,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BYTES-1:0]  mem_bw_n
);
  import xmem_pkg::*;

  timing_t           tm_in;
  phase_e            ph_q, ph_d;
  logic              restart, beat_end, tick;
  logic              wr_q, wr_d, bemode_d;
  logic [BYTES-1:0]  mask_d;
  logic [DIV_W-1:0]  div_q;

  assign tm_in = '{asu: cfg_asu, csu: cfg_csu, nwait: cfg_nwait,
                   pwait: cfg_pwait, shld: cfg_shld, ahld: cfg_ahld};

  xmem_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .div_sel (div_q),
    .tick    (tick)
  );

  xmem_ctrl #(
    .AW(ADDR_W), .DW(DATA_W), .BW(BYTES), .LW(LEN_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_down    (req_down),
    .req_len     (req_len),
    .req_addr    (req_addr),
    .req_mask    (req_mask),
    .req_wdata   (req_wdata),
    .cfg_tm      (tm_in),
    .cfg_div     (cfg_div),
    .cfg_be_mode (cfg_be_mode),
    .tick        (tick),
    .ph_q        (ph_q),
    .ph_d        (ph_d),
    .restart     (restart),
    .beat_end    (beat_end),
    .addr_q      (mem_addr),
    .wr_q        (wr_q),
    .wr_d        (wr_d),
    .bemode_d    (bemode_d),
    .mask_d      (mask_d),
    .wdata_q     (mem_dout),
    .div_q       (div_q)
  );

  xmem_pins #(.DW(DATA_W), .BW(BYTES)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .ph_q     (ph_q),
    .ph_d     (ph_d),
    .wr_q     (wr_q),
    .wr_d     (wr_d),
    .bemode_d (bemode_d),
    .mask_d   (mask_d),
    .beat_end (beat_end),
    .mem_din  (mem_din),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .bw_n     (mem_bw_n),
    .dout_en  (mem_dout_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .done     (done)
  );

  assign busy = (ph_q != PH_IDLE);

  // R1: an idle channel keeps chip enable released
  p_idle_ce_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> mem_ce_n);
endmodule

// File: tb/tb_xmem_seq.sv
`timescale 1ns/1ps
module tb_xmem_seq;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_div = '0;
  logic [3:0]  cfg_asu = '0, cfg_csu = '0, cfg_nwait = '0, cfg_pwait = '0, cfg_shld = '0, cfg_ahld = '0;
  logic        cfg_be_mode = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_down = 1'b0;
  logic [2:0]  req_len = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, rd_valid, mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n;
  logic [31:0] rd_data, mem_dout, mem_din;
  logic [15:0] mem_addr;
  logic [3:0]  mem_bw_n;

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [31:0] rdpat(input logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  assign mem_din = rdpat(mem_addr);

  always #(HALF) clk = ~clk;

  xmem_seq dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_asu(cfg_asu), .cfg_csu(cfg_csu),
    .cfg_nwait(cfg_nwait), .cfg_pwait(cfg_pwait), .cfg_shld(cfg_shld), .cfg_ahld(cfg_ahld),
    .cfg_be_mode(cfg_be_mode), .req_valid(req_valid), .req_write(req_write),
    .req_down(req_down), .req_len(req_len), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bw_n(mem_bw_n)
  );

  // monitor state, filled at falling edges
  logic        cur_wr, cur_be;
  logic [3:0]  cur_mask;
  logic [31:0] cur_wdata;
  logic [15:0] cur_addr;
  int seg;
  int segcnt [5];
  logic [15:0] addr_log [16];
  logic [31:0] rd_log [16];
  int naddr, nrd, done_cnt, bad_stb, bad_bw, bad_dq, bad_addr;

  always @(negedge clk) begin
    logic stb;
    logic [3:0] exp_bw;
    if (busy) begin
      stb = !mem_oe_n || !mem_we_n;
      if (seg == 0 && !mem_ce_n) seg = 1;
      if (seg == 1 && stb) seg = 2;
      if (seg == 2 && !stb) seg = 3;
      if (seg == 3 && mem_ce_n) seg = 4;
      segcnt[seg]++;
      if (mem_oe_n !== !(seg == 2 && !cur_wr) || mem_we_n !== !(seg == 2 && cur_wr)) bad_stb++;
      exp_bw = cur_be ? (mem_ce_n ? 4'hF : ~cur_mask) : (!mem_we_n ? ~cur_mask : 4'hF);
      if (mem_bw_n !== exp_bw) bad_bw++;
      if (mem_dout_en !== (cur_wr && !mem_ce_n)) bad_dq++;
      if (cur_wr && !mem_ce_n && mem_dout !== cur_wdata) bad_dq++;
      if (seg == 2 && (naddr == 0 || addr_log[naddr-1] != mem_addr)) begin
        if (naddr < 16) addr_log[naddr] = mem_addr;
        naddr++;
      end
      if (seg < 2 && mem_addr !== cur_addr) bad_addr++;
      if (seg > 2 && naddr > 0 && mem_addr !== addr_log[(naddr > 16) ? 15 : naddr-1]) bad_addr++;
    end
    if (done) done_cnt++;
    if (rd_valid) begin
      if (nrd < 16) rd_log[nrd] = rd_data;
      nrd++;
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic down, input int len,
                            input logic [15:0] addr, input logic [3:0] mask,
                            input logic [31:0] wdata, input logic bem, input int dv,
                            input int a_s, input int c_s, input int s_w,
                            input int p_w, input int c_h, input int a_h);
    int d, exp_stb, total, guard, mis;
    @(negedge clk);
    cur_wr = wr; cur_be = bem; cur_mask = mask; cur_wdata = wdata; cur_addr = addr;
    seg = 0; naddr = 0; nrd = 0; done_cnt = 0;
    bad_stb = 0; bad_bw = 0; bad_dq = 0; bad_addr = 0;
    for (int i = 0; i < 5; i++) segcnt[i] = 0;
    cfg_div = 2'(dv); cfg_asu = 4'(a_s); cfg_csu = 4'(c_s); cfg_nwait = 4'(s_w);
    cfg_pwait = 4'(p_w); cfg_shld = 4'(c_h); cfg_ahld = 4'(a_h); cfg_be_mode = bem;
    req_write = wr; req_down = down; req_len = 3'(len); req_addr = addr;
    req_mask = mask; req_wdata = wdata; req_valid = 1'b1;
    d = dv + 1;
    exp_stb = ((s_w + 1) + len * (p_w + 1)) * d;
    total = (a_s + c_s + c_h + a_h) * d + exp_stb;
    @(negedge clk);
    req_valid = 1'b0;
    if (total >= 3) begin
      // R13 stimulus: disturb every input while the access runs
      req_valid = 1'b1; req_addr = ~addr; req_write = !wr; req_down = !down;
      req_mask = ~mask; req_wdata = ~wdata; cfg_be_mode = !bem;
      cfg_div = 2'($urandom); cfg_asu = 4'($urandom); cfg_csu = 4'($urandom);
      cfg_nwait = 4'($urandom); cfg_pwait = 4'($urandom);
      cfg_shld = 4'($urandom); cfg_ahld = 4'($urandom);
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    #1;
    check($sformatf("R2/R3 addr setup cycles div=%0d", d), 64'(segcnt[0]), 64'(a_s * d));
    check("R4 ce setup cycles", 64'(segcnt[1]), 64'(c_s * d));
    check("R5 strobe low cycles", 64'(segcnt[2]), 64'(exp_stb));
    check("R6 strobe hold cycles", 64'(segcnt[3]), 64'(c_h * d));
    check("R7 addr hold cycles", 64'(segcnt[4]), 64'(a_h * d));
    check("R5 strobe polarity samples", 64'(bad_stb), 64'd0);
    check("R10 lane strobe samples", 64'(bad_bw), 64'd0);
    check("R11 write data samples", 64'(bad_dq), 64'd0);
    check("R7/R13 addr stability samples", 64'(bad_addr), 64'd0);
    check("R8 beat count", 64'(naddr), 64'(len + 1));
    mis = 0;
    for (int k = 0; k <= len; k++) begin
      logic [15:0] ea;
      ea = down ? addr - 16'(k) : addr + 16'(k);
      if (k < naddr && addr_log[k] !== ea) mis++;
      if (!wr && k < nrd && rd_log[k] !== rdpat(ea)) mis++;
    end
    check("R8/R9 beat address and data mismatches", 64'(mis), 64'd0);
    check("R9 read valid pulses", 64'(nrd), wr ? 64'd0 : 64'(len + 1));
    check("R12 done pulses", 64'(done_cnt), 64'd1);
    check("R1 idle levels after access", {busy, mem_ce_n, mem_oe_n, mem_we_n, mem_bw_n},
          {1'b0, 1'b1, 1'b1, 1'b1, 4'hF});
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_bw_n}, {3'b111, 4'hF});
    check("R1 reset flags", {busy, done, rd_valid}, 3'b000);

    // directed corner cases
    run_access(1'b0, 1'b0, 0, 16'h1234, 4'hF, 32'h0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    run_access(1'b1, 1'b1, 7, 16'h0003, 4'h5, 32'hDEADBEEF, 1'b1, 3, 15, 15, 15, 15, 15, 15);
    run_access(1'b0, 1'b0, 3, 16'hFFFE, 4'h9, 32'h0, 1'b1, 1, 1, 0, 2, 0, 3, 0);
    run_access(1'b1, 1'b0, 2, 16'h0100, 4'hC, 32'h01234567, 1'b0, 0, 0, 0, 2, 1, 0, 0);
    run_access(1'b0, 1'b1, 5, 16'h0000, 4'h3, 32'h0, 1'b0, 2, 0, 3, 0, 0, 0, 4);

    for (int n = 0; n < 60; n++) begin
      logic [3:0] m;
      m = 4'($urandom);
      if (m == 4'h0) m = 4'h1;
      run_access(1'($urandom), 1'($urandom), int'($urandom % 8), 16'($urandom), m,
                 $urandom, 1'($urandom), int'($urandom % 4),
                 int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                 int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule